// File: doc/BRIEF.md
# Size-Selectable Direct-Mapped Instruction Cache

This block sits between a processor's instruction-fetch port and a slower longword memory bus. It serves instruction fetches from an internal tag store and data store. A fetch that hits gets its 32-bit word back in the same cycle it is presented. A fetch that misses is turned into longword read requests on the memory bus. Each line holds four longwords, or 16 bytes. A static 3-bit size code sets how many lines are in use. Changing that code moves the boundary between the index bits and the tag bits of the fetch address.

Two refill policies are available through a mode input. Mode 0 reads only the missing longword and allocates nothing. Mode 1 refills the whole line. It starts at the missing word and wraps around the line. While the refill runs, the fetch port stays open. Words already brought in are answered from a four-entry refill buffer, hits to other lines are answered from the arrays, and the missing word itself is passed straight to the fetch port in the cycle it arrives. An invalidate input drops every line in one cycle.

Top module: `icache_sz`

## Requirements
- R1: A size code of 0 disables caching: every fetch becomes a single memory read and nothing is allocated. Size code c (1..7) selects 512 bytes << (c-1) of capacity. Codes above the build parameter MAX_CODE behave as MAX_CODE. Two addresses exactly one capacity apart map to the same line and evict each other.
- R2: A code fetch (fetch_is_code = 1) to a valid line whose tag matches gets fetch_ready = 1 in the same cycle that fetch_req is first presented. No memory request is issued for it.
- R3: The line index is taken from address bits [X:4], with X = c + 7. The tag compare uses bits [31:X+1]. As a result, addresses that differ only in bit X live in distinct lines.
- R4: A fetch with fetch_is_code = 0 is never served from, and never allocated into, the cache. It is always one memory read.
- R5: With fill_mode = 0, a code miss reads only the missing longword and allocates nothing. A repeat of the same fetch misses again.
- R6: With fill_mode = 1, a code miss to word w issues four reads at line base + 4*((w+k) mod 4), for k = 0..3, in that order. The line becomes valid only after the fourth word has been accepted.
- R7: On any miss, the requested word is returned with fetch_ready = 1 in the cycle its mem_ack arrives, with fetch_data equal to mem_rdata.
- R8: During a refill, a fetch to the line being refilled is answered at once if its word has already arrived. Otherwise it stalls until the cycle its word arrives.
- R9: During a refill, a code fetch that hits a different valid line is answered in its first cycle, without a memory read.
- R10: A one-cycle pulse on inv_all makes every line invalid. A fetch presented in that cycle while no miss is pending sees fetch_ready = 0. Every later code fetch misses until it is refilled.
- R11: If inv_all is pulsed during a refill, including the cycle of the last word, the refill still completes and delivers its words. The refilled line is nevertheless left invalid.
- R12: mem_req, once raised, stays high with a stable mem_addr until mem_ack. Each mem_ack completes exactly one longword.
- R13: After reset, fetch_ready and mem_req are low and all lines are invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| size_code | input | 3 | Static capacity code, 0 = disabled |
| fill_mode | input | 1 | Refill policy: 0 = single word, 1 = whole line |
| inv_all | input | 1 | Pulse to invalidate every line |
| fetch_req | input | 1 | Fetch request, held until fetch_ready |
| fetch_addr | input | 32 | Longword-aligned fetch address |
| fetch_is_code | input | 1 | 1 when the access is a user or supervisor code fetch |
| fetch_ready | output | 1 | Fetch completes this cycle |
| fetch_data | output | 32 | Instruction word, valid with fetch_ready |
| mem_req | output | 1 | Longword read request to memory |
| mem_addr | output | 32 | Longword address of the read |
| mem_ack | input | 1 | Read data valid, one pulse per word |
| mem_rdata | input | 32 | Read data from memory |

## Verification
Two events can land on the same clock edge: an invalidate pulse and the last word of a line refill. The bench provokes this by waiting for the final mem_ack of a refill and raising inv_all in that very cycle. It then judges the outcome by refetching the line and requiring a memory read, because the line must not have been validated. A second overlap is a hit to another line while a refill is still in flight. That hit must complete in its first cycle with no memory acknowledge in between. The address-boundary behaviour is swept over every word of a small configuration, and each returned word is compared against a data pattern computed from its address.

// File: rtl/icache_sz_pkg.sv
package icache_sz_pkg;
    localparam int ADDR_W  = 32;
    localparam int WORD_W  = 32;
    localparam int TAG_LSB = 9;
    localparam int TAG_W   = ADDR_W - TAG_LSB;
    localparam int LINE_W  = ADDR_W - 4;
    localparam int WADDR_W = ADDR_W - 2;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SINGLE = 2'd1,
        ST_FILL   = 2'd2
    } ctl_state_e;
endpackage

// File: rtl/icache_tag_store.sv
module icache_tag_store
    import icache_sz_pkg::*;
#(
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_all,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    input  logic [TAG_W-1:0] lk_mask,
    output logic             lk_hit,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             wr_valid
);
    localparam int LINES = 1 << IDX_W;

    typedef struct packed {
        logic [LINES-1:0]            valid;
        logic [LINES-1:0][TAG_W-1:0] tag;
    } tstore_t;

    tstore_t d, q;

    always_comb begin
        d = q;
        if (clr_all) begin
            d.valid = '0;
        end else if (wr_en) begin
            d.valid[wr_idx] = wr_valid;
            d.tag[wr_idx]   = wr_tag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign lk_hit = q.valid[lk_idx] && (((q.tag[lk_idx] ^ lk_tag) & lk_mask) == '0);

    // R10
    clr_then_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> !lk_hit);
endmodule

// File: rtl/icache_data_store.sv
module icache_data_store
    import icache_sz_pkg::*;
#(
    parameter int WADR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WADR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [WADR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data
);
    localparam int WORDS = 1 << WADR_W;

    typedef struct packed {
        logic [WORDS-1:0][WORD_W-1:0] word;
    } dstore_t;

    dstore_t d, q;

    always_comb begin
        d = q;
        if (wr_en) d.word[wr_addr] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_data = q.word[rd_addr];
endmodule

// File: rtl/icache_miss_ctrl.sv
module icache_miss_ctrl
    import icache_sz_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fetch_req,
    input  logic [WADDR_W-1:0] fetch_word,
    input  logic               cacheable,
    input  logic               arr_hit,
    input  logic [WORD_W-1:0]  arr_data,
    input  logic               fill_mode,
    input  logic               inv_all,
    input  logic               mem_ack,
    input  logic [WORD_W-1:0]  mem_rdata,
    output logic               fetch_ready,
    output logic [WORD_W-1:0]  fetch_data,
    output logic               mem_req,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic               dwr_en,
    output logic [1:0]         dwr_word,
    output logic [WORD_W-1:0]  dwr_data,
    output logic               twr_en,
    output logic               twr_valid,
    output logic [LINE_W-1:0]  fill_line,
    output logic               clr_all
);
    typedef struct packed {
        ctl_state_e              st;
        logic [LINE_W-1:0]       line;
        logic [1:0]              ptr;
        logic [1:0]              cnt;
        logic [3:0][WORD_W-1:0]  fbuf;
        logic [3:0]              fbv;
        logic                    stale;
        logic [WADDR_W-1:0]      saddr;
    } ctl_t;

    ctl_t d, q;
    logic [1:0] wsel;
    logic       same_line;

    assign wsel      = fetch_word[1:0];
    assign same_line = (fetch_word[WADDR_W-1:2] == q.line);

    always_comb begin
        d           = q;
        fetch_ready = 1'b0;
        fetch_data  = '0;
        mem_req     = 1'b0;
        mem_addr    = '0;
        dwr_en      = 1'b0;
        dwr_word    = q.ptr;
        dwr_data    = mem_rdata;
        twr_en      = 1'b0;
        twr_valid   = 1'b0;
        fill_line   = q.line;
        clr_all     = inv_all;

        unique case (q.st)
            ST_IDLE: begin
                if (fetch_req && !inv_all) begin
                    if (arr_hit) begin
                        fetch_ready = 1'b1;
                        fetch_data  = arr_data;
                    end else if (cacheable && fill_mode) begin
                        d.st      = ST_FILL;
                        d.line    = fetch_word[WADDR_W-1:2];
                        d.ptr     = wsel;
                        d.cnt     = 2'd0;
                        d.fbv     = '0;
                        d.stale   = 1'b0;
                        fill_line = fetch_word[WADDR_W-1:2];
                        twr_en    = 1'b1;
                        twr_valid = 1'b0;
                    end else begin
                        d.st    = ST_SINGLE;
                        d.saddr = fetch_word;
                    end
                end
            end
            ST_SINGLE: begin
                mem_req  = 1'b1;
                mem_addr = {q.saddr, 2'b00};
                if (mem_ack) begin
                    d.st = ST_IDLE;
                    if (fetch_req && fetch_word == q.saddr) begin
                        fetch_ready = 1'b1;
                        fetch_data  = mem_rdata;
                    end
                end
            end
            ST_FILL: begin
                mem_req  = 1'b1;
                mem_addr = {q.line, q.ptr, 2'b00};
                if (inv_all) d.stale = 1'b1;
                if (mem_ack) begin
                    dwr_en          = 1'b1;
                    d.fbuf[q.ptr]   = mem_rdata;
                    d.fbv[q.ptr]    = 1'b1;
                    d.ptr           = q.ptr + 2'd1;
                    d.cnt           = q.cnt + 2'd1;
                    if (q.cnt == 2'd3) begin
                        d.st      = ST_IDLE;
                        twr_en    = 1'b1;
                        twr_valid = !(q.stale || inv_all);
                    end
                end
                if (fetch_req) begin
                    if (same_line) begin
                        if (cacheable) begin
                            if (q.fbv[wsel]) begin
                                fetch_ready = 1'b1;
                                fetch_data  = q.fbuf[wsel];
                            end else if (mem_ack && q.ptr == wsel) begin
                                fetch_ready = 1'b1;
                                fetch_data  = mem_rdata;
                            end
                        end
                    end else if (arr_hit && !inv_all) begin
                        fetch_ready = 1'b1;
                        fetch_data  = arr_data;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    // R12
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R2
    ready_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_ready |-> fetch_req);

    // R10
    inv_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_all && q.st == ST_IDLE) |-> !fetch_ready);

    // R6
    fill_return_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (twr_en && twr_valid) |=> (q.st == ST_IDLE && $past(mem_ack)));
endmodule

// File: rtl/icache_sz.sv
module icache_sz
    import icache_sz_pkg::*;
#(
    parameter int MAX_CODE = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  size_code,
    input  logic        fill_mode,
    input  logic        inv_all,
    input  logic        fetch_req,
    input  logic [31:0] fetch_addr,
    input  logic        fetch_is_code,
    output logic        fetch_ready,
    output logic [31:0] fetch_data,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata
);
    localparam int IDX_W  = MAX_CODE + 4;
    localparam int WADR_W = IDX_W + 2;

    logic [2:0]          eff_code;
    logic                enabled, cacheable;
    logic [IDX_W-1:0]    idx_mask, lk_idx, fill_idx;
    logic [TAG_W-1:0]    tag_mask;
    logic                lk_hit;
    logic [WORD_W-1:0]   arr_data, dwr_data;
    logic                dwr_en, twr_en, twr_valid, clr_all;
    logic [1:0]          dwr_word;
    logic [LINE_W-1:0]   fill_line;

    assign eff_code  = (size_code > 3'(MAX_CODE)) ? 3'(MAX_CODE) : size_code;
    assign enabled   = (eff_code != 3'd0);
    assign cacheable = enabled && fetch_is_code;

    always_comb begin
        for (int i = 0; i < IDX_W; i++) idx_mask[i] = (i < int'(eff_code) + 4);
        for (int j = 0; j < TAG_W; j++) tag_mask[j] = (j + 1 >= int'(eff_code));
    end

    assign lk_idx   = fetch_addr[4 +: IDX_W] & idx_mask;
    assign fill_idx = fill_line[IDX_W-1:0] & idx_mask;

    icache_tag_store #(.IDX_W(IDX_W)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_all  (clr_all),
        .lk_idx   (lk_idx),
        .lk_tag   (fetch_addr[ADDR_W-1:TAG_LSB]),
        .lk_mask  (tag_mask),
        .lk_hit   (lk_hit),
        .wr_en    (twr_en),
        .wr_idx   (fill_idx),
        .wr_tag   (fill_line[LINE_W-1:TAG_LSB-4]),
        .wr_valid (twr_valid)
    );

    icache_data_store #(.WADR_W(WADR_W)) u_data (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr ({lk_idx, fetch_addr[3:2]}),
        .rd_data (arr_data),
        .wr_en   (dwr_en),
        .wr_addr ({fill_idx, dwr_word}),
        .wr_data (dwr_data)
    );

    icache_miss_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetch_req   (fetch_req),
        .fetch_word  (fetch_addr[ADDR_W-1:2]),
        .cacheable   (cacheable),
        .arr_hit     (lk_hit && cacheable),
        .arr_data    (arr_data),
        .fill_mode   (fill_mode),
        .inv_all     (inv_all),
        .mem_ack     (mem_ack),
        .mem_rdata   (mem_rdata),
        .fetch_ready (fetch_ready),
        .fetch_data  (fetch_data),
        .mem_req     (mem_req),
        .mem_addr    (mem_addr),
        .dwr_en      (dwr_en),
        .dwr_word    (dwr_word),
        .dwr_data    (dwr_data),
        .twr_en      (twr_en),
        .twr_valid   (twr_valid),
        .fill_line   (fill_line),
        .clr_all     (clr_all)
    );

    // R4
    bypass_from_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_ready && !cacheable) |-> (mem_ack && fetch_data == mem_rdata));

    // R2
    aligned_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> (fetch_addr[1:0] == 2'b00));
endmodule

// File: tb/icache_sz_tb.sv
module icache_sz_tb;
    localparam int MAXC = 2;
    localparam int LAT  = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  size_code = 3'd0;
    logic        fill_mode = 1'b1;
    logic        inv_all = 1'b0;
    logic        fetch_req = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        fetch_is_code = 1'b1;
    logic        fetch_ready;
    logic [31:0] fetch_data;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    int tests = 0, fails = 0, ack_cnt = 0, wcnt = 0, hold_viol = 0;
    logic [31:0] ack_log [0:63];
    logic        pend = 1'b0;
    logic [31:0] paddr = '0;

    icache_sz #(.MAX_CODE(MAXC)) u_dut (
        .clk(clk), .rst_n(rst_n), .size_code(size_code), .fill_mode(fill_mode),
        .inv_all(inv_all), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .fetch_is_code(fetch_is_code), .fetch_ready(fetch_ready), .fetch_data(fetch_data),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    always #4 clk = ~clk;

    function automatic logic [31:0] pat(input logic [31:0] a);
        return {a[15:0], a[31:16]} ^ 32'h5A5A_C3C3;
    endfunction

    task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    // memory model: answers LAT cycles after a request is seen
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
            wcnt    = 0;
        end else if (mem_req) begin
            if (wcnt == LAT - 1) begin
                mem_ack   = 1'b1;
                mem_rdata = pat(mem_addr);
                ack_log[ack_cnt % 64] = mem_addr;
                ack_cnt++;
            end else begin
                wcnt++;
            end
        end
    end

    // R12 request-hold monitor
    always @(negedge clk) begin
        #3;
        if (rst_n) begin
            if (pend && (!mem_req || mem_addr != paddr)) hold_viol++;
            pend  = mem_req && !mem_ack;
            paddr = mem_addr;
        end
    end

    task automatic fetch(input logic [31:0] a, input logic code,
                         output logic [31:0] d, output int waited, output int acks);
        int a0;
        @(negedge clk);
        fetch_req = 1'b1; fetch_addr = a; fetch_is_code = code;
        a0 = ack_cnt; waited = 0; d = '0;
        forever begin
            #2;
            if (fetch_ready) begin
                d = fetch_data;
                break;
            end
            @(negedge clk);
            waited++;
            if (waited > 100) break;
        end
        acks = ack_cnt - a0;
        @(posedge clk);
        #1 fetch_req = 1'b0;
    endtask

    // exp_acks < 0: do not check the count; w0: require zero wait
    task automatic xfetch(input logic [31:0] a, input logic code, input int exp_acks,
                          input bit w0, input string r);
        logic [31:0] d;
        int w, n;
        fetch(a, code, d, w, n);
        chk(d == pat(a) && w <= 100, r, d, pat(a));
        if (exp_acks >= 0) chk(n == exp_acks, r, 32'(n), 32'(exp_acks));
        if (w0) chk(w == 0, r, 32'(w), 32'd0);
    endtask

    task automatic settle();
        repeat (12) @(negedge clk);
    endtask

    task automatic pulse_inv();
        @(negedge clk); inv_all = 1'b1;
        @(negedge clk); inv_all = 1'b0;
    endtask

    initial begin
        int a0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R13 reset state
        chk(!fetch_ready && !mem_req, "R13", {30'd0, fetch_ready, mem_req}, 32'd0);

        // R1 disabled cache: every fetch goes to memory
        size_code = 3'd0; fill_mode = 1'b1;
        xfetch(32'h100, 1'b1, 1, 1'b0, "R1");
        xfetch(32'h100, 1'b1, 1, 1'b0, "R1");
        settle();

        size_code = 3'd1;
        pulse_inv();
        // R4 non-code fetch bypasses
        xfetch(32'h200, 1'b0, 1, 1'b0, "R4");
        xfetch(32'h200, 1'b0, 1, 1'b0, "R4");
        // R5 mode 0 does not allocate
        fill_mode = 1'b0;
        xfetch(32'h300, 1'b1, 1, 1'b0, "R5");
        xfetch(32'h300, 1'b1, 1, 1'b0, "R5");
        fill_mode = 1'b1;
        settle();

        // R6 R7 R8 wrap-around refill, forwarding and refill buffer
        a0 = ack_cnt;
        xfetch(32'h408, 1'b1, 1, 1'b0, "R7");
        xfetch(32'h40C, 1'b1, 1, 1'b0, "R8");
        xfetch(32'h408, 1'b1, 0, 1'b1, "R8");
        xfetch(32'h404, 1'b1, 2, 1'b0, "R8");
        for (int k = 0; k < 4; k++) begin
            logic [31:0] e;
            e = 32'h400 + 32'(4 * ((2 + k) % 4));
            chk(ack_log[(a0 + k) % 64] == e, "R6", ack_log[(a0 + k) % 64], e);
        end
        for (int k = 0; k < 4; k++) xfetch(32'h400 + 32'(4 * k), 1'b1, 0, 1'b1, "R2");
        settle();

        // R1 R3 sweep over 512-byte configuration
        pulse_inv();
        for (int l = 0; l < 32; l++) xfetch(32'(l * 16), 1'b1, -1, 1'b0, "R3");
        settle();
        for (int w = 0; w < 128; w++) xfetch(32'(w * 4), 1'b1, 0, 1'b1, "R2");
        xfetch(32'h200, 1'b1, 1, 1'b0, "R1");
        settle();
        xfetch(32'h000, 1'b1, 1, 1'b0, "R1");
        settle();
        xfetch(32'h010, 1'b1, 0, 1'b1, "R3");

        // R3 1 KB: bit 9 is index, both lines coexist
        size_code = 3'd2;
        pulse_inv();
        xfetch(32'h000, 1'b1, 1, 1'b0, "R3"); settle();
        xfetch(32'h200, 1'b1, 1, 1'b0, "R3"); settle();
        xfetch(32'h000, 1'b1, 0, 1'b1, "R3");
        xfetch(32'h200, 1'b1, 0, 1'b1, "R3");

        // R1 code above MAX_CODE acts as MAX_CODE (1 KB)
        size_code = 3'd3;
        pulse_inv();
        xfetch(32'h000, 1'b1, 1, 1'b0, "R1"); settle();
        xfetch(32'h400, 1'b1, 1, 1'b0, "R1"); settle();
        xfetch(32'h000, 1'b1, 1, 1'b0, "R1"); settle();

        // R9 hit to another line during a refill
        size_code = 3'd1;
        pulse_inv();
        xfetch(32'h020, 1'b1, 1, 1'b0, "R9");
        xfetch(32'h02C, 1'b1, 3, 1'b0, "R9");
        xfetch(32'h050, 1'b1, 1, 1'b0, "R9");
        xfetch(32'h024, 1'b1, 0, 1'b1, "R9");
        settle();

        // R10 invalidate stalls the fetch in its cycle, then lines miss
        @(negedge clk);
        inv_all = 1'b1; fetch_req = 1'b1; fetch_addr = 32'h024; fetch_is_code = 1'b1;
        #2 chk(!fetch_ready, "R10", {31'd0, fetch_ready}, 32'd0);
        @(negedge clk);
        inv_all = 1'b0; fetch_req = 1'b0;
        xfetch(32'h024, 1'b1, 1, 1'b0, "R10");
        settle();

        // R11 invalidate in the middle of a refill
        xfetch(32'h060, 1'b1, 1, 1'b0, "R11");
        pulse_inv();
        xfetch(32'h06C, 1'b1, -1, 1'b0, "R11");
        settle();
        xfetch(32'h060, 1'b1, 1, 1'b0, "R11");
        settle();

        // R11 invalidate in the same cycle as the last refill word
        xfetch(32'h070, 1'b1, 1, 1'b0, "R11");
        xfetch(32'h078, 1'b1, 2, 1'b0, "R11");
        for (int t = 0; t < 20; t++) begin
            @(negedge clk);
            #1;
            if (mem_ack) begin
                inv_all = 1'b1;
                @(negedge clk);
                inv_all = 1'b0;
                break;
            end
        end
        settle();
        xfetch(32'h070, 1'b1, 1, 1'b0, "R11");
        xfetch(32'h070, 1'b1, 0, 1'b1, "R8");
        settle();

        // R12 handshake monitor result
        chk(hold_viol == 0, "R12", 32'(hold_viol), 32'd0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule